// File: doc/BRIEF.md
# Host Output Buffer Arbiter with Interrupt Generation

This block sits inside a dual-channel keyboard controller and decides who owns the one output buffer that the host reads. There are four possible sources. Two are single-byte replies from the controller itself, each tagged either keyboard or auxiliary. The other two are the keyboard and auxiliary devices, which each raise a data-available flag. The block holds the owner until the host reads it. It sets the buffer-full flags and the matching output-port mirror bits, and it drives one interrupt line per channel. The mode byte controls when those lines assert.

When the host reads the data port while the buffer is full, the block clears the flags. It then captures the byte from the owning source and sends a one-cycle acknowledge to that device so that the device can advance its queue. After that, the buffer is free to re-arbitrate. A byte taken from the keyboard device starts a throttle timer, and the timer holds off re-arming for a fixed number of microseconds. A microsecond tick for this timer comes from the clock through a prescaler. Command decoding and the device-side serial links live in other blocks.

Top module: `obuf_arbiter`

## Requirements
- R1: When the buffer is empty, the winner follows this fixed priority: keyboard-tagged controller reply, then auxiliary-tagged controller reply, then keyboard device, then auxiliary device. `srcSel` reports the owner with these codes: 0 none, 1 keyboard device, 2 auxiliary device, 3 keyboard-tagged reply, 4 auxiliary-tagged reply.
- R2: Keyboard device data is ignored while `modeByte[4]` is set. Auxiliary device data is ignored while `modeByte[5]` is set. Controller replies are never masked.
- R3: Once a source wins, `obf` and `portObf` are set. `auxObf` and `portAuxObf` are also set when the winner is the auxiliary device or an auxiliary-tagged reply.
- R4: `kbdIrq` is high exactly when `obf` is 1, `auxObf` is 0, `modeByte[0]` is 1 and `modeByte[4]` is 0.
- R5: `auxIrq` is high exactly when `obf` and `auxObf` are both 1 and `modeByte[1]` is 1.
- R6: While `obf` is set, new pending data of any priority does not change the owner.
- R7: A host read (`hostRd`) while `obf` is set does three things. In that cycle it pulses the acknowledge of the owning device (`kbdAck` or `auxAck`); no acknowledge is pulsed for a reply. It loads `rdData` with the owner's byte. From the next cycle, both flags, both mirror bits and both interrupts are low.
- R8: A host read while `obf` is clear leaves `rdData` unchanged and pulses no acknowledge.
- R9: After a keyboard-device byte is read, `obf` stays low for THROTTLE_US × TICK_DIV cycles and, if anything is pending, rises on the next edge after that. After any other read, pending data re-arms on the first edge after the read.
- R10: Each reply write (`replyWr`) overwrites the single reply slot and its tag. Reading a reply clears both reply tags.
- R11: After reset, `obf`, `auxObf`, both mirror bits, both interrupts and both acknowledges are 0, `srcSel` is 0 and `rdData` is 0.
- R12: A change of `modeByte` affects the interrupt lines in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kbdAvail | input | 1 | Keyboard device has a byte ready |
| kbdByte | input | 8 | Head byte of the keyboard device |
| auxAvail | input | 1 | Auxiliary device has a byte ready |
| auxByte | input | 8 | Head byte of the auxiliary device |
| replyWr | input | 1 | Queue a controller reply this cycle |
| replyAux | input | 1 | Tag of the queued reply (1 = auxiliary) |
| replyByte | input | 8 | Controller reply byte |
| modeByte | input | 8 | Controller mode byte |
| hostRd | input | 1 | Host data-port read strobe |
| rdData | output | 8 | Last byte delivered to the host |
| obf | output | 1 | Status: output buffer full |
| auxObf | output | 1 | Status: buffer holds auxiliary-tagged data |
| portObf | output | 1 | Output-port mirror of obf |
| portAuxObf | output | 1 | Output-port mirror of auxObf |
| kbdIrq | output | 1 | Keyboard interrupt line |
| auxIrq | output | 1 | Auxiliary interrupt line |
| srcSel | output | 3 | Current owner code |
| kbdAck | output | 1 | Keyboard device byte consumed |
| auxAck | output | 1 | Auxiliary device byte consumed |

## Verification
The arbitration is driven with twelve combinations of device flags, reply tags and mode bytes. These separate the priority order, the masking of each device by its own disable bit, the fact that replies cannot be masked, and each interrupt-enable bit. Directed sequences then stack a reply on top of an owned buffer to show the owner holding. They count the exact edge on which the buffer re-arms after a keyboard read compared with a reply read. They overwrite the reply slot with the opposite tag before it is served, and they read while the buffer is empty to show that the last byte is held.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
  localparam int MODE_KIRQ_EN = 0;
  localparam int MODE_AIRQ_EN = 1;
  localparam int MODE_KOFF    = 4;
  localparam int MODE_AOFF    = 5;

  // effective-pending vector index, in priority order (lowest index wins)
  localparam int PEND_CKBD = 0;
  localparam int PEND_CAUX = 1;
  localparam int PEND_KBD  = 2;
  localparam int PEND_AUX  = 3;
  localparam int PEND_N    = 4;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_KBD  = 3'd1,
    SRC_AUX  = 3'd2,
    SRC_CKBD = 3'd3,
    SRC_CAUX = 3'd4
  } obufSrc_t;

  typedef struct packed {
    logic     arm;
    obufSrc_t grant;
    logic     take;
    logic     fetchKbd;
    logic     fetchAux;
    logic     fetchReply;
  } obufStrobe_t;

  function automatic obufSrc_t idxToSrc(input int idx);
    case (idx)
      PEND_CKBD: return SRC_CKBD;
      PEND_CAUX: return SRC_CAUX;
      PEND_KBD:  return SRC_KBD;
      PEND_AUX:  return SRC_AUX;
      default:   return SRC_NONE;
    endcase
  endfunction

  function automatic logic isAuxTagged(input obufSrc_t s);
    return (s == SRC_AUX) || (s == SRC_CAUX);
  endfunction
endpackage

// File: rtl/obuf_throttle.sv
module obuf_throttle #(
  parameter int TICK_DIV    = 50,
  parameter int THROTTLE_US = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output logic busy
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = $clog2(THROTTLE_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(THROTTLE_US);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] usLeft;
  logic             usTick;

  assign usTick = (preCnt == PRE_LAST);
  assign busy   = (usLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      usLeft <= '0;
    end else if (start) begin
      preCnt <= '0;
      usLeft <= CNT_LOAD;
    end else if (busy) begin
      if (usTick) begin
        preCnt <= '0;
        usLeft <= usLeft - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/obuf_ctrl.sv
module obuf_ctrl
  import obuf_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic              kbdAvail,
  input  logic              auxAvail,
  input  logic [1:0]        replyPend,
  input  logic [MODE_W-1:0] modeByte,
  input  logic              hostRd,
  input  logic              obfQ,
  input  logic              auxObfQ,
  input  obufSrc_t          srcQ,
  input  logic              timerBusy,
  output obufStrobe_t       stb,
  output logic              throttleStart,
  output logic              kbdIrq,
  output logic              auxIrq
);
  logic [PEND_N-1:0] effPend;
  obufSrc_t          winner;

  always_comb begin
    effPend            = '0;
    effPend[PEND_CKBD] = replyPend[0];
    effPend[PEND_CAUX] = replyPend[1];
    effPend[PEND_KBD]  = kbdAvail && !modeByte[MODE_KOFF];
    effPend[PEND_AUX]  = auxAvail && !modeByte[MODE_AOFF];
  end

  // fixed priority: scan from the lowest priority upward, last hit wins
  always_comb begin
    winner = SRC_NONE;
    for (int i = PEND_N - 1; i >= 0; i--) begin
      if (effPend[i]) winner = idxToSrc(i);
    end
  end

  always_comb begin
    stb            = '0;
    stb.take       = hostRd && obfQ;
    stb.arm        = !obfQ && !timerBusy && (|effPend);
    stb.grant      = winner;
    stb.fetchKbd   = stb.take && (srcQ == SRC_KBD);
    stb.fetchAux   = stb.take && (srcQ == SRC_AUX);
    stb.fetchReply = stb.take && ((srcQ == SRC_CKBD) || (srcQ == SRC_CAUX));
  end

  assign throttleStart = stb.fetchKbd;

  assign kbdIrq = obfQ && !auxObfQ && modeByte[MODE_KIRQ_EN] && !modeByte[MODE_KOFF];
  assign auxIrq = obfQ && auxObfQ && modeByte[MODE_AIRQ_EN];
endmodule

// File: rtl/obuf_dp.sv
module obuf_dp
  import obuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  obufStrobe_t       stb,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] auxByte,
  input  logic              replyWr,
  input  logic              replyAux,
  input  logic [DATA_W-1:0] replyByte,
  output logic              obfQ,
  output logic              auxObfQ,
  output logic              portObfQ,
  output logic              portAuxObfQ,
  output obufSrc_t          srcQ,
  output logic [1:0]        replyPend,
  output logic [DATA_W-1:0] rdDataQ
);
  logic [DATA_W-1:0] replySlot;

  // ownership flags and their output-port mirrors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      obfQ        <= 1'b0;
      auxObfQ     <= 1'b0;
      portObfQ    <= 1'b0;
      portAuxObfQ <= 1'b0;
      srcQ        <= SRC_NONE;
    end else if (stb.take) begin
      obfQ        <= 1'b0;
      auxObfQ     <= 1'b0;
      portObfQ    <= 1'b0;
      portAuxObfQ <= 1'b0;
      srcQ        <= SRC_NONE;
    end else if (stb.arm) begin
      obfQ        <= 1'b1;
      portObfQ    <= 1'b1;
      auxObfQ     <= isAuxTagged(stb.grant);
      portAuxObfQ <= isAuxTagged(stb.grant);
      srcQ        <= stb.grant;
    end
  end

  // single controller reply slot; a new write lands after a dequeue clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      replySlot <= '0;
      replyPend <= 2'b00;
    end else begin
      if (replyWr) begin
        replySlot <= replyByte;
        replyPend <= replyAux ? 2'b10 : 2'b01;
      end else if (stb.fetchReply) begin
        replyPend <= 2'b00;
      end
    end
  end

  // host-visible data register holds the last byte delivered
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (stb.fetchKbd) begin
      rdDataQ <= kbdByte;
    end else if (stb.fetchAux) begin
      rdDataQ <= auxByte;
    end else if (stb.fetchReply) begin
      rdDataQ <= replySlot;
    end
  end
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
  import obuf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MODE_W      = 8,
  parameter int TICK_DIV    = 50,
  parameter int THROTTLE_US = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbdAvail,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic              auxAvail,
  input  logic [DATA_W-1:0] auxByte,
  input  logic              replyWr,
  input  logic              replyAux,
  input  logic [DATA_W-1:0] replyByte,
  input  logic [MODE_W-1:0] modeByte,
  input  logic              hostRd,
  output logic [DATA_W-1:0] rdData,
  output logic              obf,
  output logic              auxObf,
  output logic              portObf,
  output logic              portAuxObf,
  output logic              kbdIrq,
  output logic              auxIrq,
  output logic [2:0]        srcSel,
  output logic              kbdAck,
  output logic              auxAck
);
  obufStrobe_t stb;
  obufSrc_t    srcQ;
  logic [1:0]  replyPend;
  logic        timerBusy;
  logic        throttleStart;

  obuf_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .kbdAvail      (kbdAvail),
    .auxAvail      (auxAvail),
    .replyPend     (replyPend),
    .modeByte      (modeByte),
    .hostRd        (hostRd),
    .obfQ          (obf),
    .auxObfQ       (auxObf),
    .srcQ          (srcQ),
    .timerBusy     (timerBusy),
    .stb           (stb),
    .throttleStart (throttleStart),
    .kbdIrq        (kbdIrq),
    .auxIrq        (auxIrq)
  );

  obuf_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .kbdByte     (kbdByte),
    .auxByte     (auxByte),
    .replyWr     (replyWr),
    .replyAux    (replyAux),
    .replyByte   (replyByte),
    .obfQ        (obf),
    .auxObfQ     (auxObf),
    .portObfQ    (portObf),
    .portAuxObfQ (portAuxObf),
    .srcQ        (srcQ),
    .replyPend   (replyPend),
    .rdDataQ     (rdData)
  );

  obuf_throttle #(.TICK_DIV(TICK_DIV), .THROTTLE_US(THROTTLE_US)) u_thr (
    .clk   (clk),
    .rstN  (rstN),
    .start (throttleStart),
    .busy  (timerBusy)
  );

  assign srcSel = srcQ;
  assign kbdAck = stb.fetchKbd;
  assign auxAck = stb.fetchAux;
endmodule

// File: rtl/obuf_arbiter_chk.sv
module obuf_arbiter_chk #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostRd,
  input logic [MODE_W-1:0] modeByte,
  input logic [DATA_W-1:0] rdData,
  input logic              obf,
  input logic              auxObf,
  input logic              portObf,
  input logic              portAuxObf,
  input logic              kbdIrq,
  input logic              auxIrq,
  input logic [2:0]        srcSel,
  input logic              kbdAck,
  input logic              auxAck
);
  // R3: mirrors track the status flags, aux flag only with ownership
  a_r3_mirror_follows: assert property (@(posedge clk) disable iff (!rstN)
    (portObf == obf) && (portAuxObf == auxObf) && (!auxObf || obf));

  // R4: keyboard line only for a keyboard-tagged owner with enable set
  a_r4_kbd_irq_owner: assert property (@(posedge clk) disable iff (!rstN)
    kbdIrq |-> (obf && !auxObf && modeByte[0] && !modeByte[4]));

  // R5: auxiliary line only for an auxiliary-tagged owner
  a_r5_aux_irq_owner: assert property (@(posedge clk) disable iff (!rstN)
    auxIrq |-> (obf && auxObf && modeByte[1]));

  // R6: owner holds until the host reads
  a_r6_owner_holds: assert property (@(posedge clk) disable iff (!rstN)
    (obf && !hostRd) |=> (obf && $stable(srcSel)));

  // R7: a read of a full buffer empties it on the next edge
  a_r7_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    (obf && hostRd) |=> (!obf && !kbdIrq && !auxIrq));

  // R7: at most one acknowledge, and only during a read of a full buffer
  a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({kbdAck, auxAck}) && ((kbdAck || auxAck) -> (obf && hostRd)));

  // R8: reading an empty buffer keeps the last byte
  a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!obf && hostRd) |=> $stable(rdData));

  // R9: no re-arm on the edge right after a keyboard byte is taken
  a_r9_throttle_gap: assert property (@(posedge clk) disable iff (!rstN)
    kbdAck |-> ##2 !obf);
endmodule

bind obuf_arbiter obuf_arbiter_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/obuf_arbiter_tb.sv
module obuf_arbiter_tb;
  localparam int TB_DIV = 4;
  localparam int TB_US  = 10;
  localparam int NVEC   = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       kbdAvail = 1'b0, auxAvail = 1'b0;
  logic [7:0] kbdByte = '0, auxByte = '0;
  logic       replyWr = 1'b0, replyAux = 1'b0;
  logic [7:0] replyByte = '0;
  logic [7:0] modeByte = 8'h03;
  logic       hostRd = 1'b0;
  logic [7:0] rdData;
  logic       obf, auxObf, portObf, portAuxObf, kbdIrq, auxIrq, kbdAck, auxAck;
  logic [2:0] srcSel;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  obuf_arbiter #(.TICK_DIV(TB_DIV), .THROTTLE_US(TB_US)) u_dut (
    .clk(clk), .rstN(rstN), .kbdAvail(kbdAvail), .kbdByte(kbdByte),
    .auxAvail(auxAvail), .auxByte(auxByte), .replyWr(replyWr),
    .replyAux(replyAux), .replyByte(replyByte), .modeByte(modeByte),
    .hostRd(hostRd), .rdData(rdData), .obf(obf), .auxObf(auxObf),
    .portObf(portObf), .portAuxObf(portAuxObf), .kbdIrq(kbdIrq),
    .auxIrq(auxIrq), .srcSel(srcSel), .kbdAck(kbdAck), .auxAck(auxAck)
  );

  // {kbd, aux, reply(0 none/1 kbd/2 aux), mode, src, auxObf, obf, kIrq, aIrq}
  localparam logic [18:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 2'd0, 8'h03, 3'd1, 4'b0110},
    {1'b0, 1'b1, 2'd0, 8'h03, 3'd2, 4'b1101},
    {1'b1, 1'b1, 2'd0, 8'h03, 3'd1, 4'b0110},
    {1'b1, 1'b1, 2'd0, 8'h13, 3'd2, 4'b1101},
    {1'b1, 1'b1, 2'd0, 8'h33, 3'd0, 4'b0000},
    {1'b1, 1'b1, 2'd1, 8'h03, 3'd3, 4'b0110},
    {1'b1, 1'b0, 2'd2, 8'h03, 3'd4, 4'b1101},
    {1'b0, 1'b0, 2'd1, 8'h33, 3'd3, 4'b0100},
    {1'b0, 1'b0, 2'd2, 8'h31, 3'd4, 4'b1100},
    {1'b1, 1'b0, 2'd0, 8'h00, 3'd1, 4'b0100},
    {1'b0, 1'b1, 2'd0, 8'h13, 3'd2, 4'b1101},
    {1'b1, 1'b0, 2'd0, 8'h23, 3'd1, 4'b0110}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; kbdAvail = 1'b0; auxAvail = 1'b0; replyWr = 1'b0;
    hostRd = 1'b0; modeByte = 8'h03;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic queueReply(input logic aux, input logic [7:0] b);
    replyWr = 1'b1; replyAux = aux; replyByte = b;
    @(posedge clk); @(negedge clk);
    replyWr = 1'b0;
  endtask

  task automatic readOnce();
    hostRd = 1'b1;
    @(posedge clk); @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic edgesUntilObf(output int n);
    n = 0;
    while (!obf && n < 500) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    doReset();
    // R11 reset state
    chk("R11 obf", obf, 0);
    chk("R11 auxObf", auxObf, 0);
    chk("R11 mirrors", {portObf, portAuxObf}, 0);
    chk("R11 irqs", {kbdIrq, auxIrq}, 0);
    chk("R11 acks", {kbdAck, auxAck}, 0);
    chk("R11 srcSel", srcSel, 0);
    chk("R11 rdData", rdData, 0);

    // R1 R2 R3 R4 R5: arbitration table
    for (int v = 0; v < NVEC; v++) begin
      logic [18:0] e;
      e = VECS[v];
      doReset();
      modeByte = e[14:7];
      if (e[16:15] != 2'd0) queueReply(e[16:15] == 2'd2, 8'h5A);
      else begin @(posedge clk); @(negedge clk); end
      kbdAvail = e[18]; auxAvail = e[17];
      @(posedge clk); @(negedge clk);
      chk($sformatf("R1 R2 vec%0d srcSel", v), srcSel, e[6:4]);
      chk($sformatf("R3 vec%0d flags", v), {auxObf, obf, portAuxObf, portObf},
          {e[3], e[2], e[3], e[2]});
      chk($sformatf("R4 vec%0d kbdIrq", v), kbdIrq, e[1]);
      chk($sformatf("R5 vec%0d auxIrq", v), auxIrq, e[0]);
    end

    // keyboard ownership, mode effect, owner hold, read, throttle
    doReset();
    kbdByte = 8'h1C; kbdAvail = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 kbd owner", srcSel, 1);
    modeByte = 8'h02; #1;
    chk("R12 irq drops with mode", kbdIrq, 0);
    modeByte = 8'h03; #1;
    chk("R12 irq returns with mode", kbdIrq, 1);
    queueReply(1'b0, 8'hC3);
    chk("R6 owner held over reply", srcSel, 1);
    hostRd = 1'b1; #1;
    chk("R7 kbdAck on read", {kbdAck, auxAck}, 2'b10);
    @(posedge clk); @(negedge clk);
    hostRd = 1'b0;
    chk("R7 rdData kbd", rdData, 8'h1C);
    chk("R7 flags clear", {obf, auxObf, portObf, portAuxObf, kbdIrq, auxIrq}, 0);
    kbdByte = 8'h2D;
    edgesUntilObf(n);
    chk("R9 throttle edges", n, TB_US * TB_DIV + 1);
    chk("R1 reply after throttle", srcSel, 3);
    hostRd = 1'b1; #1;
    chk("R7 no ack for reply", {kbdAck, auxAck}, 0);
    @(posedge clk); @(negedge clk);
    hostRd = 1'b0;
    chk("R7 rdData reply", rdData, 8'hC3);
    edgesUntilObf(n);
    chk("R9 no throttle after reply", n, 1);
    chk("R1 kbd re-owns", srcSel, 1);
    kbdAvail = 1'b0;
    readOnce();
    chk("R7 rdData second kbd", rdData, 8'h2D);
    hostRd = 1'b1; #1;
    chk("R8 no ack on empty read", {kbdAck, auxAck}, 0);
    @(posedge clk); @(negedge clk);
    hostRd = 1'b0;
    chk("R8 rdData held", rdData, 8'h2D);

    // reply overwrite and retag while the aux device owns the buffer
    doReset();
    auxByte = 8'h77; auxAvail = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 aux owner", srcSel, 2);
    queueReply(1'b0, 8'h11);
    queueReply(1'b1, 8'h22);
    chk("R6 aux held", srcSel, 2);
    auxAvail = 1'b0;
    hostRd = 1'b1; #1;
    chk("R7 auxAck on read", {kbdAck, auxAck}, 2'b01);
    @(posedge clk); @(negedge clk);
    hostRd = 1'b0;
    chk("R7 rdData aux", rdData, 8'h77);
    @(posedge clk); @(negedge clk);
    chk("R10 retagged reply owner", srcSel, 4);
    chk("R10 aux flag for retag", auxObf, 1);
    readOnce();
    chk("R10 overwritten byte", rdData, 8'h22);
    @(posedge clk); @(negedge clk);
    chk("R10 both tags cleared", obf, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule